// File: doc/BRIEF.md
# Byte-Wide Application Access Port

This block lets a local controller, or a small hardware sequencer, reach everything an embedded USB device function exposes through one 8-bit strobed bus. The controller sets a direction select, an 8-bit address and write data, then pulls an active-low strobe. The block synchronises the strobe to its core clock and turns each falling edge into exactly one access. The address picks one of three targets: the register side, the write port of one transmit endpoint FIFO, or the read port of one receive endpoint FIFO.

Read data is captured on the synchronised strobe edge and held on a separate 8-bit output bus until the next read. The block also keeps the notifications the controller polls: one packet-ready flag per receive FIFO, a setup-ready flag for the control endpoint, and a sticky underrun flag per receive FIFO. The register storage, the FIFO storage and the protocol engine all sit outside the block and connect as plain ports.

With default parameters the transmit windows sit at 0xF0 to 0xF3 and the receive windows at 0xF8 to 0xFB. Every other address goes to the register side.

Top module: `app_port`

## Requirements
- R1: While the synchronous active-low reset is held, every flag clears. The read bus is 0x00, and no register write, FIFO push or FIFO pop pulse is issued.
- R2: The strobe passes through a two-stage synchroniser. Each falling edge of the strobe makes exactly one access, however long the strobe then stays low.
- R3: With the select high (write), an address outside both FIFO windows gives one register write pulse that carries the address and the data. With the select low (read), an address outside the receive window loads the register read data into the read bus. The read bus then holds its value until the next read.
- R4: A write to address 0xF0+i (i below the transmit FIFO count) gives one push pulse to transmit FIFO i with the write data and no register write. If that FIFO reports full, the byte is dropped and no push is issued.
- R5: A read from address 0xF8+i (i below the receive FIFO count) on a non-empty FIFO returns its head byte and issues exactly one pop to FIFO i.
- R6: A read from an empty receive FIFO returns 0x00, issues no pop and sets that FIFO's sticky underrun flag. A write to the same receive window address clears only that flag and touches no register.
- R7: A FIFO's packet-ready flag rises on the cycle after the engine reports a complete packet for it. It falls when the controller pops the byte marked as the packet's last.
- R8: Setup-ready rises on the cycle after the engine reports a received setup stage. It stays high through seven pops of receive FIFO 0 and falls on the eighth.
- R9: A read at a transmit window address is a register read: transmit FIFOs are reached only by writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| app_wr_sel | input | 1 | 1 = write access, 0 = read access |
| app_stb_n | input | 1 | Access strobe, active low, asynchronous |
| app_addr | input | 8 | Access address |
| app_wdata | input | 8 | Write data from the controller |
| app_rdata | output | 8 | Read data to the controller, held between reads |
| pkt_rdy | output | NRX | Per receive FIFO: complete packet waiting |
| setup_rdy | output | 1 | Setup stage waiting on the control endpoint |
| rx_underrun | output | NRX | Per receive FIFO: sticky empty-read flag |
| reg_addr | output | 8 | Register side address |
| reg_wdata | output | 8 | Register side write data |
| reg_wr | output | 1 | Register side write pulse |
| reg_rdata | input | 8 | Register side read data for reg_addr |
| tx_data | output | 8 | Byte offered to the transmit FIFOs |
| tx_push | output | NTX | Per transmit FIFO push pulse |
| tx_full | input | NTX | Per transmit FIFO full indication |
| rx_data | input | 8*NRX | Head byte of each receive FIFO, FIFO i in bits 8i+7:8i |
| rx_empty | input | NRX | Per receive FIFO empty indication |
| rx_last | input | NRX | Per receive FIFO: head byte ends a packet |
| rx_pop | output | NRX | Per receive FIFO pop pulse |
| rx_pkt_done | input | NRX | Engine pulse: packet completed in FIFO i |
| setup_done | input | 1 | Engine pulse: setup stage received |

## Verification
The bench holds the strobe low for many cycles and counts pushes. A design without edge detection would stream one byte per clock instead of one per strobe. The bench reads receive FIFOs until they are empty, so a design that pops an empty FIFO or keeps stale data would show it in the returned byte and in the underrun flag. It also writes the underrun-clear address and checks that the register side was left alone. It reads transmit window addresses and window-adjacent addresses to catch an off-by-one decode. It walks the control FIFO byte by byte, so a setup-ready flag that falls one pop early or late is caught.

// File: rtl/app_port_pkg.sv
// Shared types for the application access port.
// Assumes no more than 2**FIDX_W FIFOs of each direction.
package app_port_pkg;
    localparam int FIDX_W = 3;
    typedef logic [FIDX_W-1:0] fidx_t;
    typedef enum logic [1:0] {
        TGT_REG = 2'd0,
        TGT_TX  = 2'd1,
        TGT_RX  = 2'd2
    } tgt_e;
endpackage

// File: rtl/app_stb_sync.sv
// Strobe synchroniser: brings the asynchronous active-low strobe into the
// clock domain through two flops. It gives a one-cycle pulse for each
// falling edge. Assumes the strobe stays low and high for at least
// three clocks each.
module app_stb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_n,
    output logic fall
);
    logic s1, s2, s3;

    // Synchronise and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= stb_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall = s3 & ~s2;

    // R2: an edge pulse never lasts two cycles
    p_single_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/app_addr_dec.sv
// Address decoder: sorts the 8-bit address into the transmit window,
// the receive window or the register side, and gives the FIFO index.
// Assumes the two windows do not overlap.
module app_addr_dec
    import app_port_pkg::*;
#(
    parameter int         NTX     = 4,
    parameter int         NRX     = 4,
    parameter logic [7:0] TX_BASE = 8'hF0,
    parameter logic [7:0] RX_BASE = 8'hF8
) (
    input  logic [7:0] addr,
    output tgt_e       tgt,
    output fidx_t      idx
);
    logic [7:0] tx_off, rx_off;

    // Offsets from each window base; wrap-around keeps low addresses out.
    assign tx_off = addr - TX_BASE;
    assign rx_off = addr - RX_BASE;

    // Pick the target and the index inside the window.
    always_comb begin
        tgt = TGT_REG;
        idx = '0;
        if (tx_off < 8'(NTX)) begin
            tgt = TGT_TX;
            idx = tx_off[FIDX_W-1:0];
        end else if (rx_off < 8'(NRX)) begin
            tgt = TGT_RX;
            idx = rx_off[FIDX_W-1:0];
        end
    end
endmodule

// File: rtl/app_rx_flags.sv
// Receive notifications: packet-ready per receive FIFO and setup-ready for
// the control FIFO (index 0). A completion report wins over a clearing pop
// in the same cycle. Assumes pops only occur on non-empty FIFOs.
module app_rx_flags #(
    parameter int NRX       = 4,
    parameter int SETUP_LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NRX-1:0] pop,
    input  logic [NRX-1:0] last,
    input  logic [NRX-1:0] pkt_done,
    input  logic           setup_done,
    output logic [NRX-1:0] pkt_rdy,
    output logic           setup_rdy
);
    localparam int CNT_W = (SETUP_LEN > 1) ? $clog2(SETUP_LEN) : 1;

    logic [CNT_W-1:0] setup_cnt;

    for (genvar i = 0; i < NRX; i++) begin : g_pkt
        // Set on completion, clear when the packet's last byte is popped.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pkt_rdy[i] <= 1'b0;
            else if (pkt_done[i])
                pkt_rdy[i] <= 1'b1;
            else if (pop[i] && last[i])
                pkt_rdy[i] <= 1'b0;
        end

        // R7: completion raises the flag
        p_pkt_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            pkt_done[i] |=> pkt_rdy[i]);
        // R7: popping the last byte drops the flag
        p_pkt_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (pop[i] && last[i] && !pkt_done[i]) |=> !pkt_rdy[i]);
    end

    // Track setup-ready and count the control FIFO pops since it rose.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_rdy <= 1'b0;
            setup_cnt <= '0;
        end else if (setup_done) begin
            setup_rdy <= 1'b1;
            setup_cnt <= '0;
        end else if (setup_rdy && pop[0]) begin
            if (setup_cnt == CNT_W'(SETUP_LEN - 1)) begin
                setup_rdy <= 1'b0;
                setup_cnt <= '0;
            end else begin
                setup_cnt <= setup_cnt + 1'b1;
            end
        end
    end

    // R8: a setup report raises the flag
    p_setup_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |=> setup_rdy);
    // R8: the final setup byte read drops the flag
    p_setup_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_rdy && pop[0] && !setup_done && setup_cnt == CNT_W'(SETUP_LEN - 1))
        |=> !setup_rdy);
endmodule

// File: rtl/app_port.sv
// Application access port top. Each synchronised strobe edge performs one
// access: a register write or read, a transmit FIFO push, or a receive
// FIFO read. Assumes the address, data and select are stable from before
// the strobe falls until it rises. Assumes the strobe stays low at least
// four clocks, so read data is captured before the controller samples it.
module app_port
    import app_port_pkg::*;
#(
    parameter int         NTX       = 4,
    parameter int         NRX       = 4,
    parameter logic [7:0] TX_BASE   = 8'hF0,
    parameter logic [7:0] RX_BASE   = 8'hF8,
    parameter int         SETUP_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             app_wr_sel,
    input  logic             app_stb_n,
    input  logic [7:0]       app_addr,
    input  logic [7:0]       app_wdata,
    output logic [7:0]       app_rdata,
    output logic [NRX-1:0]   pkt_rdy,
    output logic             setup_rdy,
    output logic [NRX-1:0]   rx_underrun,
    output logic [7:0]       reg_addr,
    output logic [7:0]       reg_wdata,
    output logic             reg_wr,
    input  logic [7:0]       reg_rdata,
    output logic [7:0]       tx_data,
    output logic [NTX-1:0]   tx_push,
    input  logic [NTX-1:0]   tx_full,
    input  logic [8*NRX-1:0] rx_data,
    input  logic [NRX-1:0]   rx_empty,
    input  logic [NRX-1:0]   rx_last,
    output logic [NRX-1:0]   rx_pop,
    input  logic [NRX-1:0]   rx_pkt_done,
    input  logic             setup_done
);
    logic           fall;
    logic           wr_acc, rd_acc;
    tgt_e           tgt;
    fidx_t          idx;
    logic [NRX-1:0] rx_hit_rd, rx_hit_wr;
    logic [7:0]     rx_sel_byte;
    logic           rx_sel_empty;

    app_stb_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_n (app_stb_n),
        .fall  (fall)
    );

    app_addr_dec #(
        .NTX     (NTX),
        .NRX     (NRX),
        .TX_BASE (TX_BASE),
        .RX_BASE (RX_BASE)
    ) u_dec (
        .addr (app_addr),
        .tgt  (tgt),
        .idx  (idx)
    );

    assign wr_acc    = fall & app_wr_sel;
    assign rd_acc    = fall & ~app_wr_sel;
    assign reg_addr  = app_addr;
    assign reg_wdata = app_wdata;
    assign tx_data   = app_wdata;
    assign reg_wr    = wr_acc && (tgt == TGT_REG);

    for (genvar t = 0; t < NTX; t++) begin : g_tx
        // Push only to the addressed FIFO, and only when it has room.
        assign tx_push[t] = wr_acc && (tgt == TGT_TX) && (idx == fidx_t'(t)) && !tx_full[t];
    end

    for (genvar r = 0; r < NRX; r++) begin : g_rx
        assign rx_hit_rd[r] = rd_acc && (tgt == TGT_RX) && (idx == fidx_t'(r));
        assign rx_hit_wr[r] = wr_acc && (tgt == TGT_RX) && (idx == fidx_t'(r));
        assign rx_pop[r]    = rx_hit_rd[r] && !rx_empty[r];

        // Sticky underrun: set by an empty read, cleared by a window write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rx_underrun[r] <= 1'b0;
            else if (rx_hit_rd[r] && rx_empty[r])
                rx_underrun[r] <= 1'b1;
            else if (rx_hit_wr[r])
                rx_underrun[r] <= 1'b0;
        end

        // R6: an empty read leaves the underrun flag set
        p_underrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_acc && tgt == TGT_RX && idx == fidx_t'(r) && rx_empty[r]) |=> rx_underrun[r]);
    end

    // Select the head byte and empty state of the addressed receive FIFO.
    always_comb begin
        rx_sel_byte  = 8'h00;
        rx_sel_empty = 1'b1;
        for (int r = 0; r < NRX; r++) begin
            if (idx == fidx_t'(r)) begin
                rx_sel_byte  = rx_data[r*8 +: 8];
                rx_sel_empty = rx_empty[r];
            end
        end
    end

    // Capture read data on the strobe edge and hold it until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            app_rdata <= 8'h00;
        else if (rd_acc) begin
            if (tgt == TGT_RX)
                app_rdata <= rx_sel_empty ? 8'h00 : rx_sel_byte;
            else
                app_rdata <= reg_rdata;
        end
    end

    app_rx_flags #(
        .NRX       (NRX),
        .SETUP_LEN (SETUP_LEN)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (rx_pop),
        .last       (rx_last),
        .pkt_done   (rx_pkt_done),
        .setup_done (setup_done),
        .pkt_rdy    (pkt_rdy),
        .setup_rdy  (setup_rdy)
    );

    // R3: read data holds between reads
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(app_rdata));
    // R4: at most one transmit FIFO receives a byte
    p_one_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_push));
    // R5: the port never pops an empty receive FIFO
    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop & rx_empty) == '0);
    // R3: a register write and a FIFO push never share a cycle
    p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (tx_push != '0)));
endmodule

// File: tb/app_port_tb.sv
module app_port_tb;
    localparam int NTX = 4;
    localparam int NRX = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             app_wr_sel = 1'b0;
    logic             app_stb_n = 1'b1;
    logic [7:0]       app_addr = 8'h00;
    logic [7:0]       app_wdata = 8'h00;
    logic [7:0]       app_rdata;
    logic [NRX-1:0]   pkt_rdy;
    logic             setup_rdy;
    logic [NRX-1:0]   rx_underrun;
    logic [7:0]       reg_addr, reg_wdata, reg_rdata;
    logic             reg_wr;
    logic [7:0]       tx_data;
    logic [NTX-1:0]   tx_push;
    logic [NTX-1:0]   tx_full = '0;
    logic [8*NRX-1:0] rx_data;
    logic [NRX-1:0]   rx_empty, rx_last, rx_pop;
    logic [NRX-1:0]   rx_pkt_done = '0;
    logic             setup_done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    app_port u_dut (
        .clk(clk), .rst_n(rst_n), .app_wr_sel(app_wr_sel), .app_stb_n(app_stb_n),
        .app_addr(app_addr), .app_wdata(app_wdata), .app_rdata(app_rdata),
        .pkt_rdy(pkt_rdy), .setup_rdy(setup_rdy), .rx_underrun(rx_underrun),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
        .tx_data(tx_data), .tx_push(tx_push), .tx_full(tx_full),
        .rx_data(rx_data), .rx_empty(rx_empty), .rx_last(rx_last), .rx_pop(rx_pop),
        .rx_pkt_done(rx_pkt_done), .setup_done(setup_done)
    );

    // Register side model: resets each location to its own address.
    logic [7:0] regs [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) regs[k] <= 8'(k);
        end else if (reg_wr) begin
            regs[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = regs[reg_addr];

    // Transmit side model: counts pushes and keeps the last byte.
    int         tx_cnt [NTX];
    logic [7:0] tx_byte [NTX];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NTX; t++) begin
                tx_cnt[t]  <= 0;
                tx_byte[t] <= 8'h00;
            end
        end else begin
            for (int t = 0; t < NTX; t++) begin
                if (tx_push[t]) begin
                    tx_cnt[t]  <= tx_cnt[t] + 1;
                    tx_byte[t] <= tx_data;
                end
            end
        end
    end

    // Receive side model: 16-entry queues filled by the stimulus.
    logic [7:0] rx_mem [NRX][16];
    logic       rx_lm  [NRX][16];
    logic [7:0] rx_wp  [NRX];
    logic [7:0] rx_rp  [NRX];
    initial begin
        for (int r = 0; r < NRX; r++) rx_wp[r] = 8'd0;
    end
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NRX; r++) rx_rp[r] <= 8'd0;
        end else begin
            for (int r = 0; r < NRX; r++)
                if (rx_pop[r]) rx_rp[r] <= rx_rp[r] + 8'd1;
        end
    end
    for (genvar r = 0; r < NRX; r++) begin : g_rxm
        assign rx_empty[r]       = (rx_wp[r] == rx_rp[r]);
        assign rx_data[r*8 +: 8] = rx_mem[r][rx_rp[r][3:0]];
        assign rx_last[r]        = rx_lm[r][rx_rp[r][3:0]];
    end

    task automatic load_rx(input int r, input logic [7:0] b, input logic lst);
        rx_mem[r][rx_wp[r][3:0]] = b;
        rx_lm[r][rx_wp[r][3:0]]  = lst;
        rx_wp[r] = rx_wp[r] + 8'd1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: strobe held low for `hold` clocks, then released.
    task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d, input int hold);
        @(negedge clk);
        app_wr_sel = wr;
        app_addr   = a;
        app_wdata  = d;
        app_stb_n  = 1'b0;
        repeat (hold) @(negedge clk);
        app_stb_n  = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Stimulus vectors: {write, address, data, expected read data}.
    localparam logic [24:0] VEC [0:8] = '{
        {1'b1, 8'h00, 8'h5A, 8'h00},
        {1'b1, 8'h3C, 8'hC3, 8'h00},
        {1'b1, 8'hF4, 8'h11, 8'h00},
        {1'b0, 8'h00, 8'h00, 8'h5A},
        {1'b0, 8'h3C, 8'h00, 8'hC3},
        {1'b0, 8'hF4, 8'h00, 8'h11},
        {1'b1, 8'hF1, 8'h77, 8'h00},
        {1'b1, 8'hF3, 8'h88, 8'h00},
        {1'b0, 8'hF7, 8'h00, 8'hF7}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1 rdata", app_rdata, 8'h00);
        chk("R1 flags", {pkt_rdy, rx_underrun}, 8'h00);
        chk("R1 pulses", {7'd0, reg_wr | (|tx_push) | (|rx_pop)}, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: register and transmit traffic from the vector table
        for (int v = 0; v < 9; v++) begin
            access(VEC[v][24], VEC[v][23:16], VEC[v][15:8], 4);
            if (!VEC[v][24]) chk("R3 read", app_rdata, VEC[v][7:0]);
        end
        // R4: window writes went to FIFOs, not registers
        chk("R4 tx1 count", 8'(tx_cnt[1]), 8'd1);
        chk("R4 tx1 byte", tx_byte[1], 8'h77);
        chk("R4 tx3 byte", tx_byte[3], 8'h88);
        chk("R4 tx0 count", 8'(tx_cnt[0]), 8'd0);
        // R9: a read of a transmit window address returns register data
        access(1'b0, 8'hF1, 8'h00, 4);
        chk("R9 tx addr read", app_rdata, 8'hF1);
        chk("R9 no tx effect", 8'(tx_cnt[1]), 8'd1);

        // R2: a long strobe makes one push only
        access(1'b1, 8'hF0, 8'h42, 20);
        chk("R2 long strobe", 8'(tx_cnt[0]), 8'd1);
        // R4: full FIFO drops the byte
        tx_full[2] = 1'b1;
        access(1'b1, 8'hF2, 8'h99, 4);
        chk("R4 full drop", 8'(tx_cnt[2]), 8'd0);
        tx_full[2] = 1'b0;

        // R7: packet-ready on FIFO 1
        load_rx(1, 8'hA1, 1'b0);
        load_rx(1, 8'hA2, 1'b1);
        @(negedge clk); rx_pkt_done[1] = 1'b1;
        @(negedge clk); rx_pkt_done[1] = 1'b0;
        chk("R7 set", {7'd0, pkt_rdy[1]}, 8'd1);
        access(1'b0, 8'hF9, 8'h00, 4);
        chk("R5 head byte", app_rdata, 8'hA1);
        chk("R7 held mid packet", {7'd0, pkt_rdy[1]}, 8'd1);
        access(1'b0, 8'hF9, 8'h00, 4);
        chk("R5 second byte", app_rdata, 8'hA2);
        chk("R7 cleared on last", {7'd0, pkt_rdy[1]}, 8'd0);
        // R6: empty read
        access(1'b0, 8'hF9, 8'h00, 4);
        chk("R6 empty data", app_rdata, 8'h00);
        chk("R6 no pop", rx_rp[1], 8'd2);
        chk("R6 underrun set", {4'd0, rx_underrun}, 8'h02);
        access(1'b1, 8'hF9, 8'h5F, 4);
        chk("R6 underrun clear", {4'd0, rx_underrun}, 8'h00);
        chk("R6 register untouched", regs[8'hF9], 8'hF9);

        // R8: setup stage on FIFO 0
        for (int b = 0; b < 8; b++) load_rx(0, 8'(8'h10 + b), b == 7);
        @(negedge clk); setup_done = 1'b1;
        @(negedge clk); setup_done = 1'b0;
        chk("R8 set", {7'd0, setup_rdy}, 8'd1);
        for (int b = 0; b < 7; b++) begin
            access(1'b0, 8'hF8, 8'h00, 4);
            chk("R5 setup byte", app_rdata, 8'(8'h10 + b));
        end
        chk("R8 held after seven", {7'd0, setup_rdy}, 8'd1);
        access(1'b0, 8'hF8, 8'h00, 4);
        chk("R5 setup byte", app_rdata, 8'h17);
        chk("R8 cleared after eight", {7'd0, setup_rdy}, 8'd0);

        // R1: reset mid-run clears flags and read bus
        @(negedge clk); rx_pkt_done[2] = 1'b1;
        @(negedge clk); rx_pkt_done[2] = 1'b0;
        access(1'b0, 8'hFB, 8'h00, 4);
        chk("R6 underrun fifo3", {4'd0, rx_underrun}, 8'h08);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset flags", {pkt_rdy, rx_underrun}, 8'h00);
        chk("R1 reset setup", {7'd0, setup_rdy}, 8'd0);
        chk("R1 reset rdata", app_rdata, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule